// File: doc/BRIEF.md
# Power Management Event Timer

A free-running up-counter whose width is fixed at build time (24 or 32 bits in deployment). It advances once for every clock cycle on which a one-cycle tick pulse arrives. The tick comes at the reference rate of 3.579545 MHz, so the whole block runs on a single system clock. Software reads the live count through a registered read port and never writes it. Each time the most significant count bit flips, a sticky status flag is raised. This happens twice per full wrap. Software can count these half-wrap events and so extend the hardware count into a wider virtual timer.

An enable bit gates the status onto a level event request. Software clears the status by writing a one to it and programs the enable through the same control word. If a flip of the top bit coincides with a clear, the status stays set, so no half-wrap is ever lost. The counter reset value is zero to keep simulation repeatable. Software must not depend on that value.

Top module: `pmt_timer`

## Requirements
- R1: After reset, the count is 0, status is 0, enable is 0, the event output is low and the read data is 0.
- R2: On every clock edge that samples tick_i high, the count rises by one, wrapping modulo 2^CNT_W. When tick_i is low, the count holds.
- R3: Status becomes 1 on the same clock edge at which count bit CNT_W-1 changes value. This applies to the 0-to-1 change and to the 1-to-0 change at the wrap.
- R4: Status sets on a top-bit change whatever the value of enable.
- R5: evt_o is high exactly while both status and enable are 1, and stays high until one of them is cleared.
- R6: A write to address 1 loads enable from data bit 1. The write clears status when data bit 0 is 1 and leaves status unchanged when data bit 0 is 0.
- R7: If a top-bit change and a status-clearing write happen on the same edge, status is 1 after that edge.
- R8: A write to address 0 (the count address) has no effect on the count.
- R9: The read data register samples on every edge. One cycle after rd_addr_i is presented, rd_data_o holds either the whole count as it stood before that edge, zero-extended (address 0), or {enable, status} in bits 1 and 0 with zeros above (address 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count advance pulse at the reference rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 count (read-only), 1 control |
| wr_data_i | input | 32 | Write data: bit 0 clears status, bit 1 is enable |
| rd_addr_i | input | 1 | Read address: 0 count, 1 control |
| rd_data_o | output | 32 | Registered read data |
| evt_o | output | 1 | Level event request |

## Verification
The bench uses an 8-bit counter, so the top bit flips every 128 ticks. A steady tick stream runs through several full wraps. This separates a correct top-bit detector from one that fires on only one direction or on the wrong bit. Random tick gaps, mixed with random control writes and reads, show whether the count really holds between ticks and whether the clear, enable and event interact correctly. Directed cases place a clear on the exact edge of a top-bit flip and hammer the count address with writes. These two cases expose a wrong clear priority and a writable count.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned CTRL_STS_BIT = 0;
  localparam int unsigned CTRL_EN_BIT = 1;

  typedef enum logic {
    ADDR_COUNT = 1'b0,
    ADDR_CTRL  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             toggle_o
);
  localparam int unsigned MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  // top bit flips on the next increment when all lower bits are ones
  assign toggle_o = tick_i & (&cnt_q[MSB-1:0]);
  assign cnt_o    = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_TOGGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[MSB] != $past(cnt_q[MSB])) |-> $past(toggle_o)); // R3
endmodule

// File: rtl/pmt_event.sv
module pmt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  output logic sts_o,
  output logic en_o,
  output logic evt_o
);
  logic sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      // toggle wins over a simultaneous clear
      if (toggle_i) sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
      if (en_we_i) en_q <= en_wd_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign evt_o = sts_q & en_q;

  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_i |=> sts_q); // R3
  AST_CLR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_i && clr_i) |=> sts_q); // R7
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !toggle_i) |=> !sts_q); // R6
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !toggle_i) |=> $stable(sts_q)); // R6
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q)); // R6
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sts_i,
  input  logic             en_i,
  output logic             clr_o,
  output logic             en_we_o,
  output logic             en_wd_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic             ctrl_wr;
  logic [REG_W-1:0] cnt_ext, ctrl_word, rd_d, rd_q;
  logic             unused_wr;

  assign ctrl_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign clr_o   = ctrl_wr && wr_data_i[CTRL_STS_BIT];
  assign en_we_o = ctrl_wr;
  assign en_wd_o = wr_data_i[CTRL_EN_BIT];
  assign unused_wr = ^wr_data_i[REG_W-1:2];

  generate
    if (CNT_W < REG_W) begin : g_pad
      assign cnt_ext = {{(REG_W-CNT_W){1'b0}}, cnt_i};
    end else begin : g_full
      assign cnt_ext = cnt_i;
    end
  endgenerate

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_STS_BIT] = sts_i;
    ctrl_word[CTRL_EN_BIT]  = en_i;
  end

  assign rd_d = (reg_addr_e'(rd_addr_i) == ADDR_CTRL) ? ctrl_word : cnt_ext;

  // one-edge snapshot of every bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  AST_RD_CTRL_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_e'(rd_addr_i) == ADDR_CTRL) |=> rd_q[REG_W-1:2] == '0); // R9
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        evt_o
);
  logic [CNT_W-1:0] cnt;
  logic             toggle, clr, en_we, en_wd, sts, en;

  generate
    if (CNT_W < 4 || CNT_W > REG_W) begin : g_bad_width
      $error("pmt_timer: CNT_W out of range");
    end
  endgenerate

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_o    (cnt),
    .toggle_o (toggle)
  );

  pmt_event u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i (toggle),
    .clr_i    (clr),
    .en_we_i  (en_we),
    .en_wd_i  (en_wd),
    .sts_o    (sts),
    .en_o     (en),
    .evt_o    (evt_o)
  );

  pmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .sts_i     (sts),
    .en_i      (en),
    .clr_o     (clr),
    .en_we_o   (en_we),
    .en_wd_o   (en_wd),
    .rd_data_o (rd_data_o)
  );

  AST_CNT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i && !tick_i) |=> $stable(cnt)); // R8
  AST_STS_ANY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt[CNT_W-1] != $past(cnt[CNT_W-1])) |-> sts); // R4
  AST_EVT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> en && sts); // R5
endmodule

// File: tb/sim_pmt_timer.sv
`timescale 1ns/1ps
module sim_pmt_timer;
  localparam int unsigned W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        evt;

  int unsigned tests = 0, fails = 0;
  bit          done = 1'b0;

  logic [W-1:0] m_cnt = '0;
  logic         m_sts = 1'b0, m_en = 1'b0;
  logic [31:0]  m_rd = '0;

  always #2.5 clk = ~clk;

  pmt_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .evt_o(evt)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act %h exp %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic t, input logic we, input logic wa, input logic [31:0] wd,
                      input logic ra, input string tag);
    logic tog;
    tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    tog  = t && (m_cnt[W-2:0] == '1);
    m_rd = ra ? {30'b0, m_en, m_sts} : {24'b0, m_cnt};
    if (t) m_cnt = m_cnt + 1'b1;
    if (tog) m_sts = 1'b1;
    else if (we && wa && wd[0]) m_sts = 1'b0;
    if (we && wa) m_en = wd[1];
    @(negedge clk);
    chk(tag, "rd_data", rd_data, m_rd);
    chk("R5", "evt", {31'b0, evt}, {31'b0, m_sts & m_en});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act hung exp done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rd_data in reset", rd_data, 32'h0);
    chk("R1", "evt in reset", {31'b0, evt}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, "R1");

    // R2 R3 R4: steady ticks, enable off, several wraps
    for (int i = 0; i < 700; i++) begin
      step(1, 0, 0, 0, i[0], (i[0] ? "R4" : "R2"));
      if (m_cnt == 8'h80 || m_cnt == 8'h00) begin
        step(0, 0, 0, 0, 1, "R3");
        step(0, 1, 1, 32'h1, 1, "R6");
      end
    end

    // R6 R5: enable with status pending, then clear leaves evt low
    while (m_cnt[W-2:0] != '1) step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 1, "R3");
    step(0, 1, 1, 32'h2, 1, "R6");
    chk("R5", "evt after enable", {31'b0, evt}, 32'h1);
    step(0, 1, 1, 32'h2, 1, "R6");
    chk("R6", "status kept by zero write", {31'b0, m_sts}, 32'h1);
    step(0, 1, 1, 32'h3, 1, "R6");
    chk("R5", "evt after clear", {31'b0, evt}, 32'h0);

    // R7: clear on the same edge as a top-bit flip
    while (m_cnt[W-2:0] != '1) step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 32'h3, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    chk("R7", "status after collision", rd_data, 32'h3);

    // R8: writes to the count address
    step(0, 1, 1, 32'h1, 0, "R8");
    for (int i = 0; i < 20; i++) step(i[0], 1, 0, 32'hFFFF_FFFF ^ i, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, "R8");

    // R9 R2 R6: random tick gaps, writes and reads
    for (int i = 0; i < 6000; i++) begin
      automatic logic [31:0] r = $urandom;
      step(r[0] | r[1], r[8:2] == 0, r[9], {30'b0, r[11:10]}, r[12], "R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule